// File: doc/BRIEF.md
# Banked Data Memory with Indirect Access

This unit is the data store of a small 8-bit processing core. It spans a 128-byte address space. Addresses 20H to 7FH are general-purpose RAM. The 32 locations below 20H form the special-function area, which holds the core's control registers. A parameter mask marks which of those 32 locations exist, and a second mask marks which of them are read-only. Every location the first mask leaves out reads as zero, and a write to it is dropped.

Two of the special-function locations hold memory pointers, at 01H and 03H. Each pointer has a virtual port address next to it: 00H for the first pointer and 02H for the second. An access to a port address does not touch the port. The access goes instead to the location named by the low seven bits of the matching pointer.

Reads are combinational from the address. Byte writes commit at the rising clock edge. Single-bit set and clear operations also commit at the rising edge, and they follow the same pointer redirection as byte writes. The core sends one access per cycle through this interface.

Top module: `dmem_unit`

## Requirements
- R1: A byte written to any address from 20H to 7FH is visible on `rdData` from the cycle after the write edge. Reads are combinational from `addr`.
- R2: An access to address 00H is carried out on the location given by bits 6:0 of the pointer register at 01H. This applies to reads, writes and bit operations.
- R3: An access to address 02H is carried out on the location given by bits 6:0 of the pointer register at 03H. This applies to reads, writes and bit operations.
- R4: With the default mask, the reserved locations 19H and 1FH read 00H. A byte write or a bit operation at a reserved location leaves it reading 00H.
- R5: Location 1BH is read-only under the default masks. A byte write to it is ignored, so it keeps reading 00H after reset.
- R6: When `bitEn` is 1, bit `bitIdx` of the resolved target is set (`bitSet`=1) or cleared (`bitSet`=0), and all other bits keep their value. When `wrEn` and `bitEn` are both 1, the byte write wins.
- R7: If the selected pointer's bits 6:0 equal 00H or 02H, a read of the port returns 00H. In that case writes and bit operations through the port change nothing.
- R8: While `rstN` is low, the pointers and all special-function storage clear to 00H. General-purpose RAM keeps its contents across a reset.
- R9: Writable special-function locations store and return full bytes. Location 04H is one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Access address |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Byte to write |
| bitEn | input | 1 | Single-bit operation strobe |
| bitIdx | input | 3 | Bit position for the bit operation |
| bitSet | input | 1 | 1 sets the bit, 0 clears it |
| rdData | output | 8 | Combinational read of the resolved location |

## Verification
The bench uses the default masks. With them, the reserved slots 19H and 1FH and the read-only slot 1BH can all be reached, so the tests can show that writes to those slots are dropped and that the slots read zero. The 7-bit address width makes both ends of the RAM (20H and 7FH) reachable as pointer targets. The width also lets a pointer be aimed at a port address, which drives the recursion guard.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic              sfrWe;
    logic              gpWe;
    logic [ADDR_W-1:0] tgt;
    logic [DATA_W-1:0] val;
  } dmemStrobe_t;
endpackage

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
#(
  parameter int          GP_BASE   = 32,
  parameter logic [31:0] IMPL_MASK = 32'h7DFF_FFFA,
  parameter logic [31:0] RO_MASK   = 32'h0800_0000,
  parameter int          PORT0     = 0,
  parameter int          PORT1     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bitEn,
  input  logic [2:0]        bitIdx,
  input  logic              bitSet,
  input  logic [DATA_W-1:0] mp0,
  input  logic [DATA_W-1:0] mp1,
  input  logic [DATA_W-1:0] tgtRead,
  output logic [ADDR_W-1:0] tgt,
  output logic [DATA_W-1:0] rdData,
  output dmemStrobe_t       strobe
);
  localparam int SFR_W = $clog2(GP_BASE);

  logic viaPort, badLoop, isGp, writable, doWrite;
  logic [SFR_W-1:0]  sfrIdx;
  logic [DATA_W-1:0] bitMask, newVal;

  always_comb begin
    viaPort = 1'b1;
    if (addr == ADDR_W'(PORT0))      tgt = mp0[ADDR_W-1:0];
    else if (addr == ADDR_W'(PORT1)) tgt = mp1[ADDR_W-1:0];
    else begin
      tgt     = addr;
      viaPort = 1'b0;
    end
    badLoop  = viaPort && (tgt == ADDR_W'(PORT0) || tgt == ADDR_W'(PORT1));
    isGp     = tgt >= ADDR_W'(GP_BASE);
    sfrIdx   = tgt[SFR_W-1:0];
    writable = !isGp && IMPL_MASK[sfrIdx] && !RO_MASK[sfrIdx];
    doWrite  = (wrEn || bitEn) && !badLoop;
    bitMask  = DATA_W'(1) << bitIdx;
    if (wrEn)        newVal = wrData;
    else if (bitSet) newVal = tgtRead | bitMask;
    else             newVal = tgtRead & ~bitMask;
    rdData       = badLoop ? '0 : tgtRead;
    strobe.gpWe  = doWrite && isGp;
    strobe.sfrWe = doWrite && writable;
    strobe.tgt   = tgt;
    strobe.val   = newVal;
  end

  // R7: a port whose pointer aims at a port returns zero and writes nothing
  a_r7_loop_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(PORT0) && (mp0[ADDR_W-1:0] == ADDR_W'(PORT0) ||
                                mp0[ADDR_W-1:0] == ADDR_W'(PORT1)))
    |-> (rdData == '0 && !strobe.gpWe && !strobe.sfrWe));

  // R4: direct access to a reserved special-function slot reads zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr < ADDR_W'(GP_BASE) && addr != ADDR_W'(PORT0) &&
     addr != ADDR_W'(PORT1) && !IMPL_MASK[addr[SFR_W-1:0]]) |-> rdData == '0);

  // R6: only one storage class is written per cycle
  a_r6_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.gpWe, strobe.sfrWe}));
endmodule

// File: rtl/dmem_datapath.sv
module dmem_datapath
  import dmem_pkg::*;
#(
  parameter int          GP_BASE   = 32,
  parameter logic [31:0] IMPL_MASK = 32'h7DFF_FFFA,
  parameter logic [31:0] RO_MASK   = 32'h0800_0000,
  parameter int          PORT0     = 0,
  parameter int          PORT1     = 2,
  parameter int          PTR0      = 1,
  parameter int          PTR1      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdTgt,
  input  dmemStrobe_t       strobe,
  output logic [DATA_W-1:0] tgtRead,
  output logic [DATA_W-1:0] mp0,
  output logic [DATA_W-1:0] mp1
);
  localparam int SFR_W = $clog2(GP_BASE);
  localparam int GP_N  = (1 << ADDR_W) - GP_BASE;
  // Port addresses never hold storage
  localparam logic [31:0] STORE_MASK =
    IMPL_MASK & ~(32'd1 << PORT0) & ~(32'd1 << PORT1);

  logic [DATA_W-1:0] sfrQ [GP_BASE];
  logic [DATA_W-1:0] gpRam [GP_N];
  logic [ADDR_W-1:0] gpIdx, rdIdx;

  for (genvar i = 0; i < GP_BASE; i++) begin : g_sfr
    if (STORE_MASK[i]) begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (strobe.sfrWe && strobe.tgt == ADDR_W'(i)) q <= strobe.val;
      end
      assign sfrQ[i] = q;
    end else begin : g_hole
      assign sfrQ[i] = '0;
    end
  end

  assign gpIdx = strobe.tgt - ADDR_W'(GP_BASE);
  assign rdIdx = rdTgt - ADDR_W'(GP_BASE);

  always_ff @(posedge clk) begin
    if (strobe.gpWe) gpRam[gpIdx] <= strobe.val;
  end

  assign tgtRead = (rdTgt >= ADDR_W'(GP_BASE)) ? gpRam[rdIdx]
                                               : sfrQ[rdTgt[SFR_W-1:0]];
  assign mp0 = sfrQ[PTR0];
  assign mp1 = sfrQ[PTR1];

  // R5: control must never strobe a read-only or absent slot
  a_r5_sfr_guard: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sfrWe |-> (IMPL_MASK[strobe.tgt[SFR_W-1:0]] &&
                      !RO_MASK[strobe.tgt[SFR_W-1:0]]));

  // R1: a RAM write is present in storage after the edge
  a_r1_gp_commit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gpWe |=> gpRam[$past(gpIdx)] == $past(strobe.val));

  // R8: pointers stay cleared while reset is held
  a_r8_ptr_reset: assert property (@(posedge clk)
    !rstN |=> (mp0 == '0 && mp1 == '0));
endmodule

// File: rtl/dmem_unit.sv
module dmem_unit
  import dmem_pkg::*;
#(
  parameter int          GP_BASE   = 32,
  parameter logic [31:0] IMPL_MASK = 32'h7DFF_FFFA,
  parameter logic [31:0] RO_MASK   = 32'h0800_0000,
  parameter int          PORT0     = 0,
  parameter int          PORT1     = 2,
  parameter int          PTR0      = 1,
  parameter int          PTR1      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bitEn,
  input  logic [2:0]        bitIdx,
  input  logic              bitSet,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mp0, mp1, tgtRead;
  logic [ADDR_W-1:0] tgt;
  dmemStrobe_t       strobe;

  dmem_ctrl #(
    .GP_BASE(GP_BASE), .IMPL_MASK(IMPL_MASK), .RO_MASK(RO_MASK),
    .PORT0(PORT0), .PORT1(PORT1)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .bitEn(bitEn), .bitIdx(bitIdx), .bitSet(bitSet), .mp0(mp0), .mp1(mp1),
    .tgtRead(tgtRead), .tgt(tgt), .rdData(rdData), .strobe(strobe)
  );

  dmem_datapath #(
    .GP_BASE(GP_BASE), .IMPL_MASK(IMPL_MASK), .RO_MASK(RO_MASK),
    .PORT0(PORT0), .PORT1(PORT1), .PTR0(PTR0), .PTR1(PTR1)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rdTgt(tgt), .strobe(strobe),
    .tgtRead(tgtRead), .mp0(mp0), .mp1(mp1)
  );
endmodule

// File: tb/tb_dmem_unit.sv
`timescale 1ns/1ps
module tb_dmem_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] addr = '0;
  logic       wrEn = 1'b0, bitEn = 1'b0, bitSet = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] bitIdx = '0;
  logic [7:0] rdData;
  int checks = 0, errors = 0;
  bit done = 0;

  dmem_unit dut (.*);

  always #5 clk = ~clk;

  // kind: 0 byte write, 1 bit op, 2 idle
  typedef struct packed {
    logic [1:0] kind; logic [6:0] a; logic [7:0] d;
    logic [2:0] bi;   logic bs;      logic [6:0] chk;
    logic [7:0] exp;  logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h20, 8'hA5, 3'd0, 1'b0, 7'h20, 8'hA5, 4'd1}, // R1 low end
    '{2'd0, 7'h7F, 8'h3C, 3'd0, 1'b0, 7'h7F, 8'h3C, 4'd1}, // R1 top end
    '{2'd0, 7'h04, 8'h5A, 3'd0, 1'b0, 7'h04, 8'h5A, 4'd9}, // R9
    '{2'd0, 7'h01, 8'h30, 3'd0, 1'b0, 7'h01, 8'h30, 4'd2}, // R2 pointer load
    '{2'd0, 7'h00, 8'h77, 3'd0, 1'b0, 7'h30, 8'h77, 4'd2}, // R2 write via port
    '{2'd0, 7'h03, 8'h7F, 3'd0, 1'b0, 7'h03, 8'h7F, 4'd3}, // R3 pointer load
    '{2'd0, 7'h02, 8'hE1, 3'd0, 1'b0, 7'h7F, 8'hE1, 4'd3}, // R3 write via port
    '{2'd2, 7'h00, 8'h00, 3'd0, 1'b0, 7'h00, 8'h77, 4'd2}, // R2 read via port
    '{2'd2, 7'h00, 8'h00, 3'd0, 1'b0, 7'h02, 8'hE1, 4'd3}, // R3 read via port
    '{2'd0, 7'h19, 8'hFF, 3'd0, 1'b0, 7'h19, 8'h00, 4'd4}, // R4
    '{2'd0, 7'h1F, 8'h12, 3'd0, 1'b0, 7'h1F, 8'h00, 4'd4}, // R4
    '{2'd1, 7'h19, 8'h00, 3'd0, 1'b1, 7'h19, 8'h00, 4'd4}, // R4 bit op
    '{2'd0, 7'h1B, 8'hAB, 3'd0, 1'b0, 7'h1B, 8'h00, 4'd5}, // R5
    '{2'd1, 7'h20, 8'h00, 3'd1, 1'b1, 7'h20, 8'hA7, 4'd6}, // R6 set
    '{2'd1, 7'h20, 8'h00, 3'd7, 1'b0, 7'h20, 8'h27, 4'd6}, // R6 clear
    '{2'd1, 7'h00, 8'h00, 3'd3, 1'b1, 7'h30, 8'h7F, 4'd6}, // R6 via port 0
    '{2'd1, 7'h02, 8'h00, 3'd0, 1'b0, 7'h7F, 8'hE0, 4'd6}, // R6 via port 1
    '{2'd0, 7'h01, 8'h02, 3'd0, 1'b0, 7'h00, 8'h00, 4'd7}, // R7 loop read
    '{2'd0, 7'h00, 8'h99, 3'd0, 1'b0, 7'h7F, 8'hE0, 4'd7}  // R7 loop write
  };

  task automatic doOp(input logic [1:0] kind, input logic [6:0] a,
                      input logic [7:0] d, input logic [2:0] bi, input logic bs);
    @(negedge clk);
    addr = a; wrData = d; bitIdx = bi; bitSet = bs;
    wrEn = (kind == 2'd0); bitEn = (kind == 2'd1);
    @(posedge clk); #1;
    wrEn = 1'b0; bitEn = 1'b0;
  endtask

  task automatic check(input logic [6:0] a, input logic [7:0] exp, input string req);
    addr = a; #1;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, rdData, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R8 reset state
    check(7'h01, 8'h00, "R8");
    check(7'h03, 8'h00, "R8");
    check(7'h04, 8'h00, "R8");
    check(7'h00, 8'h00, "R7"); // pointer 0 aims at 00H after reset
    for (int i = 0; i < NV; i++) begin
      doOp(VECS[i].kind, VECS[i].a, VECS[i].d, VECS[i].bi, VECS[i].bs);
      check(VECS[i].chk, VECS[i].exp, $sformatf("R%0d", VECS[i].req));
    end
    // R7: bit op through looped port leaves everything intact
    doOp(2'd1, 7'h00, 8'h00, 3'd4, 1'b1);
    check(7'h7F, 8'hE0, "R7");
    check(7'h03, 8'h7F, "R7");
    // R6 priority: byte write beats bit op
    @(negedge clk);
    addr = 7'h21; wrData = 8'h11; wrEn = 1'b1; bitEn = 1'b1; bitIdx = 3'd7; bitSet = 1'b1;
    @(posedge clk); #1; wrEn = 1'b0; bitEn = 1'b0;
    check(7'h21, 8'h11, "R6");
    // R8 second reset: storage clears, RAM kept
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check(7'h01, 8'h00, "R8");
    check(7'h04, 8'h00, "R8");
    check(7'h20, 8'h27, "R8");
    check(7'h21, 8'h11, "R8");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule